// File: doc/BRIEF.md
# TDM Switch Output Channel Controller

This block is the output side of a time-slot interchange for 8 serial streams, each carrying 32 byte-wide channels per frame at one bit per clock. It captures every input stream into a double-buffered data memory. At the end of each channel slot it reads the connection entry for the coming channel of every output stream. From that entry each output channel either takes the byte captured one frame earlier at a chosen source stream and channel, or sends the stored byte itself as a message. The byte is shifted out MSB first.

The driver of each output is controlled at two levels. A global drive-enable pin, when low, puts every output in the high-impedance state at once. When that pin is high, each channel's own enable bit decides. A global message-enable input forces message mode and the per-channel enable on for every channel. The connection memory is outside the block: the block gives the channel index it wants and reads one entry per stream on wide buses. The frame counter runs freely from reset and marks the start of each frame.

Top module: `tsi_out_ctrl`

## Requirements
- R1: `frame_o` is high for one cycle every 256 cycles, first in the cycle after reset is released. Channel c occupies cycles 8c to 8c+7 after that pulse, with bit 7 sent first and bit 0 last, on both inputs and outputs.
- R2: In switched mode, the connection byte names the source: bits 7:5 give the source stream and bits 4:0 the source channel. The output channel then carries the byte that arrived on that stream and channel in the previous frame. This includes source channel 31 switched into output channel 0 of the next frame.
- R3: When the message flag (bit 1 of a stream's control pair) is set, the output channel carries the connection byte itself.
- R4: When `ode_i` is low, every bit of `ser_oe_o` and `ser_o` is 0 in the same cycle, whatever the per-channel settings.
- R5: When `ode_i` is high, `ser_oe_o[s]` follows the channel's enable flag (bit 0 of its control pair) for the whole channel slot. `ser_o[s]` is 0 whenever its enable is low.
- R6: When `msg_en_i` is 1 at a channel's fetch, that channel behaves as if both its message flag and its enable flag were set, whatever their stored values.
- R7: `cm_chan_o` equals the index of the next channel, wrapping 31 to 0, and changes only after a fetch. The entries for stream s sit at `cm_lo_i[8s+7:8s]` and `cm_hi_i[2s+1:2s]`, and are sampled in the last bit cycle of the preceding channel.
- R8: During reset and through channel 0 of the first frame all outputs are undriven. The data memory starts cleared, so switched channels in the first frame send 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ode_i | input | 1 | Global output drive enable |
| msg_en_i | input | 1 | Global message enable |
| ser_i | input | STREAMS | Serial input streams |
| cm_chan_o | output | log2(CHANS) | Channel index of the connection entries requested |
| cm_lo_i | input | STREAMS*8 | Connection byte per stream: source or message byte |
| cm_hi_i | input | STREAMS*2 | Control pair per stream: bit 1 message, bit 0 enable |
| ser_o | output | STREAMS | Serial output data, 0 when undriven |
| ser_oe_o | output | STREAMS | Driver enable per output stream |
| frame_o | output | 1 | Frame start, marks channel 0 bit 7 |

## Verification
The bench uses the default 8 streams by 32 channels, so a frame is 256 cycles. Ten frames then cover the first frame after reset, the parity swap of the data memory banks, and the wrap case where source channel 31 feeds output channel 0 of the next frame. At this size every source stream and every channel index can be set through a permutation in a single frame. Mid-frame toggles of the drive enable and whole frames with it low are reachable without long runs.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int BYTE_W = 8;

  // per-stream control pair from the connection memory
  typedef struct packed {
    logic msg;
    logic oe;
  } cm_ctl_t;

  localparam int CTL_W = $bits(cm_ctl_t);
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer #(
  parameter int CHANS = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  output logic [$clog2(CHANS)-1:0] chan_o,
  output logic [$clog2(CHANS)-1:0] next_chan_o,
  output logic                     last_o,
  output logic                     frame_o,
  output logic                     wrap_o,
  output logic                     wr_bank_o,
  output logic                     rd_bank_o
);
  localparam int CH_W  = $clog2(CHANS);
  localparam int BIT_W = $clog2(tsi_pkg::BYTE_W);

  logic [CH_W-1:0]  chan_q;
  logic [BIT_W-1:0] bit_q;
  logic             par_q;

  assign last_o  = (bit_q == BIT_W'(tsi_pkg::BYTE_W - 1));
  assign wrap_o  = (chan_q == CH_W'(CHANS - 1));
  assign frame_o = (chan_q == '0) && (bit_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= '0;
      bit_q  <= '0;
      par_q  <= 1'b0;
    end else if (last_o) begin
      bit_q <= '0;
      if (wrap_o) begin
        chan_q <= '0;
        par_q  <= ~par_q;
      end else begin
        chan_q <= chan_q + CH_W'(1);
      end
    end else begin
      bit_q <= bit_q + BIT_W'(1);
    end
  end

  assign chan_o      = chan_q;
  assign next_chan_o = wrap_o ? '0 : chan_q + CH_W'(1);
  assign wr_bank_o   = par_q;
  // next channel 0 belongs to the next frame: read the bank filling now
  assign rd_bank_o   = wrap_o ? par_q : ~par_q;
endmodule

// File: rtl/tsi_rx_capture.sv
module tsi_rx_capture #(
  parameter int STREAMS = 8,
  parameter int CHANS   = 32
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [STREAMS-1:0]                    ser_i,
  input  logic [$clog2(CHANS)-1:0]              chan_i,
  input  logic                                  last_i,
  input  logic                                  wrap_i,
  input  logic                                  wr_bank_i,
  input  logic                                  rd_bank_i,
  input  logic [STREAMS*tsi_pkg::BYTE_W-1:0]    rd_src_i,
  output logic [STREAMS*tsi_pkg::BYTE_W-1:0]    rd_data_o
);
  localparam int BW     = tsi_pkg::BYTE_W;
  localparam int CH_W   = $clog2(CHANS);
  localparam int STRM_W = $clog2(STREAMS);

  logic [BW-2:0] sh_q   [STREAMS];
  logic [BW-1:0] done_w [STREAMS];
  logic [BW-1:0] mem_q  [2][STREAMS][CHANS];

  always_comb begin
    for (int s = 0; s < STREAMS; s++) done_w[s] = {sh_q[s], ser_i[s]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STREAMS; s++) begin
        sh_q[s] <= '0;
        for (int b = 0; b < 2; b++)
          for (int c = 0; c < CHANS; c++) mem_q[b][s][c] <= '0;
      end
    end else begin
      for (int s = 0; s < STREAMS; s++) begin
        sh_q[s] <= done_w[s][BW-2:0];
        if (last_i) mem_q[wr_bank_i][s][chan_i] <= done_w[s];
      end
    end
  end

  for (genvar o = 0; o < STREAMS; o++) begin : g_rd
    logic [STRM_W-1:0] src_strm;
    logic [CH_W-1:0]   src_ch;
    assign src_strm = rd_src_i[o*BW+CH_W +: STRM_W];
    assign src_ch   = rd_src_i[o*BW +: CH_W];
    // last channel of the frame is still arriving: forward it
    assign rd_data_o[o*BW +: BW] = (wrap_i && src_ch == CH_W'(CHANS - 1))
                                   ? done_w[src_strm]
                                   : mem_q[rd_bank_i][src_strm][src_ch];
  end
endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic                      msg_en_i,
  input  logic                      ode_i,
  input  tsi_pkg::cm_ctl_t          ctl_i,
  input  logic [tsi_pkg::BYTE_W-1:0] lo_i,
  input  logic [tsi_pkg::BYTE_W-1:0] sw_i,
  output logic                      ser_o,
  output logic                      oe_o
);
  localparam int BW = tsi_pkg::BYTE_W;

  logic [BW-1:0] sh_q;
  logic          oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else if (load_i) begin
      sh_q <= (msg_en_i || ctl_i.msg) ? lo_i : sw_i;
      oe_q <= msg_en_i || ctl_i.oe;
    end else begin
      sh_q <= {sh_q[BW-2:0], 1'b0};
    end
  end

  assign oe_o  = ode_i & oe_q;
  assign ser_o = oe_o & sh_q[BW-1];
endmodule

// File: rtl/tsi_out_ctrl.sv
module tsi_out_ctrl #(
  parameter int STREAMS = 8,
  parameter int CHANS   = 32
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               ode_i,
  input  logic                               msg_en_i,
  input  logic [STREAMS-1:0]                 ser_i,
  output logic [$clog2(CHANS)-1:0]           cm_chan_o,
  input  logic [STREAMS*tsi_pkg::BYTE_W-1:0] cm_lo_i,
  input  logic [STREAMS*tsi_pkg::CTL_W-1:0]  cm_hi_i,
  output logic [STREAMS-1:0]                 ser_o,
  output logic [STREAMS-1:0]                 ser_oe_o,
  output logic                               frame_o
);
  localparam int BW   = tsi_pkg::BYTE_W;
  localparam int CW   = tsi_pkg::CTL_W;
  localparam int CH_W = $clog2(CHANS);

  logic [CH_W-1:0]       chan_w;
  logic                  last_w, wrap_w, wr_bank_w, rd_bank_w;
  logic [STREAMS*BW-1:0] sw_data_w;

  tsi_frame_timer #(.CHANS(CHANS)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chan_o      (chan_w),
    .next_chan_o (cm_chan_o),
    .last_o      (last_w),
    .frame_o     (frame_o),
    .wrap_o      (wrap_w),
    .wr_bank_o   (wr_bank_w),
    .rd_bank_o   (rd_bank_w)
  );

  // connection byte doubles as the {stream, channel} source address
  tsi_rx_capture #(.STREAMS(STREAMS), .CHANS(CHANS)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ser_i     (ser_i),
    .chan_i    (chan_w),
    .last_i    (last_w),
    .wrap_i    (wrap_w),
    .wr_bank_i (wr_bank_w),
    .rd_bank_i (rd_bank_w),
    .rd_src_i  (cm_lo_i),
    .rd_data_o (sw_data_w)
  );

  for (genvar s = 0; s < STREAMS; s++) begin : g_lane
    tsi_pkg::cm_ctl_t ctl;
    assign ctl = tsi_pkg::cm_ctl_t'(cm_hi_i[s*CW +: CW]);

    tsi_tx_lane u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (last_w),
      .msg_en_i (msg_en_i),
      .ode_i    (ode_i),
      .ctl_i    (ctl),
      .lo_i     (cm_lo_i[s*BW +: BW]),
      .sw_i     (sw_data_w[s*BW +: BW]),
      .ser_o    (ser_o[s]),
      .oe_o     (ser_oe_o[s])
    );
  end
endmodule

// File: rtl/tsi_out_ctrl_chk.sv
module tsi_out_ctrl_chk #(
  parameter int STREAMS = 8,
  parameter int CHANS   = 32
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     ode_i,
  input logic                     msg_en_i,
  input logic                     ld_i,
  input logic                     frame_o,
  input logic [STREAMS-1:0]       ser_o,
  input logic [STREAMS-1:0]       ser_oe_o,
  input logic [$clog2(CHANS)-1:0] cm_chan_o
);
  localparam int FRAME_LEN = CHANS * tsi_pkg::BYTE_W;
  localparam int GW        = $clog2(FRAME_LEN) + 1;

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (frame_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + GW'(1);
    end
  end

  assert_frame_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_o && seen_q) |-> (gap_q == GW'(FRAME_LEN - 1)));

  assert_hiz_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ode_i |-> (ser_oe_o == '0 && ser_o == '0));

  assert_undriven_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_o & ~ser_oe_o) == '0);

  assert_oe_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> (!$stable(ode_i) || $stable(ser_oe_o)));

  assert_msg_en_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && msg_en_i) |=> (!ode_i || (&ser_oe_o)));

  assert_chan_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(cm_chan_o));
endmodule

bind tsi_out_ctrl tsi_out_ctrl_chk #(.STREAMS(STREAMS), .CHANS(CHANS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ode_i     (ode_i),
  .msg_en_i  (msg_en_i),
  .ld_i      (last_w),
  .frame_o   (frame_o),
  .ser_o     (ser_o),
  .ser_oe_o  (ser_oe_o),
  .cm_chan_o (cm_chan_o)
);

// File: tb/tsi_out_ctrl_tb_top.sv
`timescale 1ns/1ps
module tsi_out_ctrl_tb_top;
  localparam int NS  = 8;
  localparam int NC  = 32;
  localparam int FL  = NC * 8;
  localparam int NFR = 10;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            ode = 1'b1;
  logic            msg_en = 1'b0;
  logic [NS-1:0]   ser_in = '0;
  logic [4:0]      cm_chan;
  logic [NS*8-1:0] cm_lo;
  logic [NS*2-1:0] cm_hi;
  logic [NS-1:0]   ser_out, ser_oe;
  logic            frame;

  always #2.5 clk = ~clk;

  tsi_out_ctrl #(.STREAMS(NS), .CHANS(NC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ode_i(ode), .msg_en_i(msg_en),
    .ser_i(ser_in), .cm_chan_o(cm_chan), .cm_lo_i(cm_lo), .cm_hi_i(cm_hi),
    .ser_o(ser_out), .ser_oe_o(ser_oe), .frame_o(frame)
  );

  logic [7:0] cml [NS][NC];
  logic [1:0] cmh [NS][NC];

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      cm_lo[s*8 +: 8] = cml[s][cm_chan];
      cm_hi[s*2 +: 2] = cmh[s][cm_chan];
    end
  end

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [7:0] exp_byte [NS];
  bit         exp_oe   [NS];
  string      exp_tag  [NS];

  function automatic logic [7:0] in_byte(int f, int s, int c);
    if (f < 0) return 8'h00;
    return 8'(f * 37 + s * 29 + c * 11 + 5);
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic apply_frame(int p);
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++) begin
        case (p)
          2: begin // reversed: ch31 sources land in ch0 (R2 wrap)
            cml[s][c] = {3'(NS - 1 - s), 5'(NC - 1 - c)};
            cmh[s][c] = 2'b01;
          end
          3, 5: begin
            if (c % 2 == 0) begin
              cml[s][c] = {3'((s + 3) % NS), 5'((c * 5) % NC)};
              cmh[s][c] = {1'b0, ((s + c) % 5) != 0};
            end else begin
              cml[s][c] = 8'((s * 16 + c) ^ 8'hA5);
              cmh[s][c] = {1'b1, ((s + c) % 5) != 0};
            end
          end
          4: begin
            cml[s][c] = 8'((s * 32 + c) ^ 8'h5A);
            cmh[s][c] = 2'b00;
          end
          6, 7: begin
            cml[s][c] = {3'd2, 5'd31};
            cmh[s][c] = 2'b01;
          end
          default: begin
            cml[s][c] = {3'(s), 5'(c)};
            cmh[s][c] = 2'b01;
          end
        endcase
      end
    msg_en = (p == 4);
  endtask

  task automatic drive(int k);
    logic [7:0] v;
    for (int s = 0; s < NS; s++) begin
      v = in_byte(k / FL, s, (k % FL) / 8);
      ser_in[s] = v[7 - (k % 8)];
    end
    ode = !((k >= 5 * FL + 40 && k < 5 * FL + 100) || (k / FL == 7));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    apply_frame(0);
    drive(0);
    for (int s = 0; s < NS; s++) begin
      exp_byte[s] = 8'h00;
      exp_oe[s]   = 1'b0;
      exp_tag[s]  = "R8";
    end
    repeat (3) begin
      @(negedge clk);
      check("R8", "oe during reset", 32'(ser_oe), 32'h0);
      check("R8", "data during reset", 32'(ser_out), 32'h0);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < NFR * FL; k++) begin
      int b, c;
      cyc = k;
      b = k % 8;
      c = (k % FL) / 8;
      check("R1", "frame pulse", 32'(frame), 32'(k % FL == 0));
      check("R7", "channel request", 32'(cm_chan), 32'((c + 1) % NC));
      for (int s = 0; s < NS; s++) begin
        bit eo, ed;
        eo = ode && exp_oe[s];
        ed = eo && exp_byte[s][7 - b];
        check(!ode ? "R4" : exp_tag[s], $sformatf("stream %0d {oe,data}", s),
              32'({ser_oe[s], ser_out[s]}), 32'({eo, ed}));
      end
      if (b == 7) begin
        int nk, tf, nc;
        nk = k + 1;
        tf = nk / FL;
        nc = (nk % FL) / 8;
        for (int s = 0; s < NS; s++) begin
          logic [7:0] lo;
          logic [1:0] hi;
          bit m;
          lo = cml[s][nc];
          hi = cmh[s][nc];
          m  = msg_en || hi[1];
          exp_oe[s]   = msg_en || hi[0];
          exp_byte[s] = m ? lo : in_byte(tf - 1, int'(lo[7:5]), int'(lo[4:0]));
          if (!m && tf == 0)  exp_tag[s] = "R8";
          else if (msg_en)    exp_tag[s] = "R6";
          else if (!hi[0])    exp_tag[s] = "R5";
          else if (m)         exp_tag[s] = "R3";
          else                exp_tag[s] = "R2";
        end
      end
      @(posedge clk);
      #1;
      if ((k + 1) % FL == 0) apply_frame((k + 1) / FL);
      drive(k + 1);
      @(negedge clk);
    end
    done = 1;
    summary();
    $finish;
  end
endmodule